// File: doc/BRIEF.md
# Run-Length Child-Pointer Compressor

This block turns the child-pointer array of one decision-tree node into its compact form. The array arrives as a stream with one entry per cycle, in sub-space order. The first entry carries a start marker and the final entry carries a last marker. For every entry whose pointer differs from the entry just before it, the block sets the matching bit of a change bitmap and sends that pointer out on a unique-pointer stream. A run of equal neighbouring pointers therefore costs one bitmap bit and one stored pointer.

Bit positions keep the sub-space order, so bit 0 belongs to entry 0. A later consumer rebuilds entry n by counting the set bits in positions 0 to n and reading the compressed array at that count minus one. The same pointer value may come back after a different run and is then stored again. The block detects changes between neighbours, not distinct values.

Once the last entry is taken, the bitmap and the unique-pointer count are final. The block flags this with a one-cycle pulse and then holds both values until the next start marker. A start marker may follow the last entry on the very next cycle.

Top module: `cpa_encoder`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, bitmap and out_count are zero until the first start entry. While reset is applied, bitmap_valid and out_valid are low.
- R2: An entry taken with in_start high is entry 0. It clears the previous bitmap and count. In the cycle after it, bitmap equals 1 (only bit 0 set), out_count is 1, out_valid is high and out_ptr is that entry's pointer.
- R3: For entry i with i > 0, bitmap bit i is set if and only if its pointer differs from the pointer of entry i-1. Bit i is bit i of the bitmap port, with bit 0 as the least significant bit.
- R4: In the cycle after each entry that sets a bitmap bit, out_valid is high and out_ptr carries that entry's pointer. Unique pointers leave in entry order, and out_valid is low in all other cycles.
- R5: out_count always equals the number of set bits in bitmap.
- R6: bitmap_valid is high for exactly one cycle, the cycle after the entry marked in_last. Bitmap and out_count then hold their values until the next start entry.
- R7: Arrays may follow each other with no idle cycle: a start entry in the cycle after a last entry begins a new array, and each array gets its own bitmap_valid pulse with its own bitmap and count.
- R8: Cycles with in_valid low inside an array do not advance the entry position and do not change any output.
- R9: Entries with in_valid high that arrive after a last entry and before the next start entry are ignored. They produce no out_valid and no bitmap_valid, and they leave bitmap and out_count unchanged.
- R10: Entries beyond position N_ENTRIES-1 in one array are ignored. The in_last marker on such an entry still produces the bitmap_valid pulse.
- R11: An entry with both in_start and in_last high forms a one-entry array: bitmap 1, out_count 1, and a bitmap_valid pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An array entry is present this cycle |
| in_start | input | 1 | This entry is entry 0 of a new array |
| in_last | input | 1 | This entry is the final entry of the array |
| in_ptr | input | PTR_W | Child pointer of this entry |
| bitmap | output | N_ENTRIES | Change bitmap; bit i set when entry i starts a new run |
| bitmap_valid | output | 1 | One-cycle pulse: bitmap and out_count are final |
| out_valid | output | 1 | A unique pointer is on out_ptr |
| out_ptr | output | PTR_W | Pointer appended to the compressed array |
| out_count | output | $clog2(N_ENTRIES+1) | Number of unique pointers emitted for the current array |

## Verification
The properties assume that the input markers are only meaningful together with in_valid. They also assume that the inputs are held low while reset is applied and during the two synchronizer cycles after it, and that a start entry is the only way to begin an array. The bench drives every field to zero whenever in_valid is low. It waits out the reset release before the first entry, and it sends stray entries after a completed array only on purpose, without a start marker, to exercise R9. The bench shrinks the array to 16 entries so that whole frames, frames longer than the array, and back-to-back frames stay short.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;

  // Per-entry decision made by the run detector, consumed by the bitmap
  // accumulator and the pointer emitter.
  typedef struct packed {
    logic accept;  // entry lies inside an open array and below N_ENTRIES
    logic fresh;   // entry begins a new run of pointers
    logic first;   // entry is entry 0 (start marker)
    logic done;    // entry carries the last marker of an open array
  } cpa_evt_t;

endpackage

// File: rtl/cpa_run_detect.sv
`timescale 1ns/1ps
module cpa_run_detect
  import cpa_pkg::*;
#(
  parameter int N_ENTRIES = 256,
  parameter int PTR_W     = 16,
  localparam int POS_W    = $clog2(N_ENTRIES),
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic             in_last,
  input  logic [PTR_W-1:0] in_ptr,
  output cpa_evt_t         evt_o,
  output logic [POS_W-1:0] pos_o
);

  logic             frame_q, frame_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [PTR_W-1:0] prev_q;
  logic [CNT_W-1:0] cur_pos;
  logic             take;
  logic             accept;
  logic             fresh;

  // next-state logic
  always_comb begin
    cur_pos = in_start ? '0 : pos_q;
    take    = in_valid && (in_start || frame_q);
    accept  = take && (cur_pos < CNT_W'(N_ENTRIES));
    fresh   = accept && (in_start || (in_ptr != prev_q));

    frame_d = frame_q;
    pos_d   = pos_q;
    if (take) begin
      frame_d = !in_last;
      pos_d   = cur_pos + CNT_W'(accept);
    end
  end

  // state registers, enabled by an accepted or closing entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      pos_q   <= '0;
    end else if (take) begin
      frame_q <= frame_d;
      pos_q   <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (accept) begin
      prev_q <= in_ptr;
    end
  end

  assign evt_o.accept = accept;
  assign evt_o.fresh  = fresh;
  assign evt_o.first  = accept && in_start;
  assign evt_o.done   = take && in_last;
  assign pos_o        = cur_pos[POS_W-1:0];

endmodule

// File: rtl/cpa_bitmap_acc.sv
`timescale 1ns/1ps
module cpa_bitmap_acc
  import cpa_pkg::*;
#(
  parameter int N_ENTRIES = 256,
  localparam int POS_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cpa_evt_t             evt_i,
  input  logic [POS_W-1:0]     pos_i,
  output logic [N_ENTRIES-1:0] bitmap_o,
  output logic                 bm_valid_o
);

  logic [N_ENTRIES-1:0] bm_q;
  logic                 bv_q;
  logic                 clr;

  assign clr = evt_i.first;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_bit
    logic hit;
    logic en;
    logic d;

    always_comb begin
      hit = evt_i.fresh && (pos_i == POS_W'(i));
      en  = clr || hit;
      d   = clr ? (i == 0) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bm_q[i] <= 1'b0;
      end else if (en) begin
        bm_q[i] <= d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv_q <= 1'b0;
    end else begin
      bv_q <= evt_i.done && evt_i.accept | evt_i.done;
    end
  end

  assign bitmap_o   = bm_q;
  assign bm_valid_o = bv_q;

endmodule

// File: rtl/cpa_ptr_emit.sv
`timescale 1ns/1ps
module cpa_ptr_emit #(
  parameter int N_ENTRIES = 256,
  parameter int PTR_W     = 16,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fresh_i,
  input  logic             first_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             out_valid_o,
  output logic [PTR_W-1:0] out_ptr_o,
  output logic [CNT_W-1:0] out_count_o
);

  logic             ov_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = first_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
    end else begin
      ov_q <= fresh_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (fresh_i) begin
      ptr_q <= ptr_i;
      cnt_q <= cnt_d;
    end
  end

  assign out_valid_o = ov_q;
  assign out_ptr_o   = ptr_q;
  assign out_count_o = cnt_q;

endmodule

// File: rtl/cpa_encoder.sv
`timescale 1ns/1ps
module cpa_encoder
  import cpa_pkg::*;
#(
  parameter int N_ENTRIES = 256,
  parameter int PTR_W     = 16,
  localparam int POS_W    = $clog2(N_ENTRIES),
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic                 in_last,
  input  logic [PTR_W-1:0]     in_ptr,
  output logic [N_ENTRIES-1:0] bitmap,
  output logic                 bitmap_valid,
  output logic                 out_valid,
  output logic [PTR_W-1:0]     out_ptr,
  output logic [CNT_W-1:0]     out_count
);

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  cpa_evt_t         evt;
  logic [POS_W-1:0] pos;

  cpa_run_detect #(
    .N_ENTRIES (N_ENTRIES),
    .PTR_W     (PTR_W)
  ) u_detect (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .in_ptr   (in_ptr),
    .evt_o    (evt),
    .pos_o    (pos)
  );

  cpa_bitmap_acc #(
    .N_ENTRIES (N_ENTRIES)
  ) u_bitmap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt_i      (evt),
    .pos_i      (pos),
    .bitmap_o   (bitmap),
    .bm_valid_o (bitmap_valid)
  );

  cpa_ptr_emit #(
    .N_ENTRIES (N_ENTRIES),
    .PTR_W     (PTR_W)
  ) u_emit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fresh_i     (evt.fresh),
    .first_i     (evt.first),
    .ptr_i       (in_ptr),
    .out_valid_o (out_valid),
    .out_ptr_o   (out_ptr),
    .out_count_o (out_count)
  );

endmodule

// File: rtl/cpa_encoder_chk.sv
`timescale 1ns/1ps
module cpa_encoder_chk #(
  parameter int N_ENTRIES = 256,
  parameter int PTR_W     = 16,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 in_valid,
  input logic                 in_start,
  input logic                 in_last,
  input logic [PTR_W-1:0]     in_ptr,
  input logic [N_ENTRIES-1:0] bitmap,
  input logic                 bitmap_valid,
  input logic                 out_valid,
  input logic [PTR_W-1:0]     out_ptr,
  input logic [CNT_W-1:0]     out_count
);

  // R5: count and bitmap population agree
  p_count_pop_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (32'(out_count) == $countones(bitmap)));

  // R2: a start entry resets the array to a single run
  p_start_emit_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_start) |=>
      (out_valid && out_ptr == $past(in_ptr) && bitmap[0] &&
       out_count == CNT_W'(1)));

  // R3: outside a start, at most one new bitmap bit per cycle
  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_valid && in_start) |=> ($countones(bitmap ^ $past(bitmap)) <= 1));

  // R6: outside a start, set bits are never cleared
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_valid && in_start) |=> ((bitmap & $past(bitmap)) == $past(bitmap)));

  // R4: a unique pointer leaves exactly when the count advances
  p_emit_cnt_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_valid && in_start) |=> (out_valid == (out_count != $past(out_count))));

  // R8: an idle cycle produces no output event
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> (!out_valid && !bitmap_valid));

  // R11: start together with last closes a one-entry array
  p_single_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_start && in_last) |=>
      (bitmap_valid && bitmap == N_ENTRIES'(1)));

endmodule

bind cpa_encoder cpa_encoder_chk #(
  .N_ENTRIES (N_ENTRIES),
  .PTR_W     (PTR_W)
) u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .in_valid     (in_valid),
  .in_start     (in_start),
  .in_last      (in_last),
  .in_ptr       (in_ptr),
  .bitmap       (bitmap),
  .bitmap_valid (bitmap_valid),
  .out_valid    (out_valid),
  .out_ptr      (out_ptr),
  .out_count    (out_count)
);

// File: tb/cpa_encoder_bench.sv
`timescale 1ns/1ps
module cpa_encoder_bench;

  localparam int N  = 16;
  localparam int PW = 8;
  localparam int CW = $clog2(N + 1);
  localparam int NROWS = 4;

  // stimulus rows: entry i in bits [8i+7:8i]
  localparam logic [127:0] STIM [NROWS] = '{
    128'h05050505050505050505050505050505,  // one run
    128'h0F0E0D0C0B0A09080706050403020100,  // all different
    128'h22222222222222222222222211111111,  // runs 0..3 and 4..15
    128'h09090707090907070909070709090707   // repeating values, pairs
  };
  localparam logic [15:0] EXP_BM  [NROWS] = '{16'h0001, 16'hFFFF, 16'h0011, 16'h5555};
  localparam int          EXP_CNT [NROWS] = '{1, 16, 2, 8};

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_start, in_last;
  logic [PW-1:0] in_ptr;
  logic [N-1:0]  bitmap;
  logic          bitmap_valid, out_valid;
  logic [PW-1:0] out_ptr;
  logic [CW-1:0] out_count;

  cpa_encoder #(.N_ENTRIES(N), .PTR_W(PW)) u_cpa_encoder (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_start (in_start), .in_last (in_last),
    .in_ptr (in_ptr), .bitmap (bitmap), .bitmap_valid (bitmap_valid),
    .out_valid (out_valid), .out_ptr (out_ptr), .out_count (out_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // output collector, sampling between edges
  logic [PW-1:0] got [64];
  int            ng  = 0;
  logic [N-1:0]  bm_hist  [16];
  logic [CW-1:0] cnt_hist [16];
  int            nbv = 0;

  always @(negedge clk) begin
    if (out_valid && ng < 64) begin
      got[ng] = out_ptr;
      ng = ng + 1;
    end
    if (bitmap_valid && nbv < 16) begin
      bm_hist[nbv]  = bitmap;
      cnt_hist[nbv] = out_count;
      nbv = nbv + 1;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic l,
                       input logic [PW-1:0] p);
    @(negedge clk);
    in_valid = v; in_start = s; in_last = l; in_ptr = p;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic send_vec(input logic [127:0] v, input bit gaps);
    for (int i = 0; i < N; i++) begin
      drive(1'b1, i == 0, i == N - 1, v[8*i +: 8]);
      if (gaps && (i % 2 == 1)) idle();
      if (gaps && (i % 5 == 2)) begin idle(); idle(); end
    end
  endtask

  // unique pointers implied by R3/R4 for a stimulus row
  task automatic chk_ptrs(input logic [127:0] v, input int base, input string tag);
    int k = base;
    for (int i = 0; i < N; i++) begin
      if (i == 0 || v[8*i +: 8] != v[8*(i-1) +: 8]) begin
        chk(got[k] == v[8*i +: 8], tag, 64'(got[k]), 64'(v[8*i +: 8]));
        k++;
      end
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b;
    in_valid = 0; in_start = 0; in_last = 0; in_ptr = '0;
    rst_n = 0;
    #1;
    // R1: reset state while reset is applied
    chk(bitmap == '0,       "R1 bitmap in reset",   64'(bitmap), 0);
    chk(out_count == '0,    "R1 count in reset",    64'(out_count), 0);
    chk(!bitmap_valid,      "R1 bitmap_valid low",  64'(bitmap_valid), 0);
    chk(!out_valid,         "R1 out_valid low",     64'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(bitmap == '0 && out_count == '0, "R1 state after release", 64'(bitmap), 0);

    // table walk: R2 R3 R4 R5 R6
    for (int r = 0; r < NROWS; r++) begin
      ng = 0; b = nbv;
      send_vec(STIM[r], 1'b0);
      idle();
      #1;
      chk(nbv == b + 1,            "R6 one bitmap_valid pulse", 64'(nbv - b), 1);
      chk(bm_hist[b] == EXP_BM[r], "R3 bitmap",                 64'(bm_hist[b]), 64'(EXP_BM[r]));
      chk(32'(cnt_hist[b]) == EXP_CNT[r], "R5 count",           64'(cnt_hist[b]), 64'(EXP_CNT[r]));
      chk(ng == EXP_CNT[r],        "R4 unique pointer number",  64'(ng), 64'(EXP_CNT[r]));
      chk(got[0] == STIM[r][7:0],  "R2 first pointer",          64'(got[0]), 64'(STIM[r][7:0]));
      chk_ptrs(STIM[r], 0, "R4 pointer order");
      repeat (3) idle();
      #1;
      chk(bitmap == EXP_BM[r] && 32'(out_count) == EXP_CNT[r], "R6 hold after pulse",
          64'(bitmap), 64'(EXP_BM[r]));
      chk(nbv == b + 1, "R6 no extra pulse", 64'(nbv - b), 1);
    end

    // R8: idle gaps inside an array
    ng = 0; b = nbv;
    send_vec(STIM[3], 1'b1);
    idle();
    #1;
    chk(bm_hist[b] == 16'h5555, "R8 bitmap with gaps", 64'(bm_hist[b]), 64'h5555);
    chk(ng == 8,                "R8 pointers with gaps", 64'(ng), 8);
    chk_ptrs(STIM[3], 0, "R8 pointer order with gaps");

    // R7: back-to-back arrays
    ng = 0; b = nbv;
    send_vec(STIM[2], 1'b0);
    send_vec(STIM[0], 1'b0);
    idle();
    #1;
    chk(nbv == b + 2,             "R7 two pulses",       64'(nbv - b), 2);
    chk(bm_hist[b] == 16'h0011,   "R7 first bitmap",     64'(bm_hist[b]), 64'h0011);
    chk(cnt_hist[b] == CW'(2),    "R7 first count",      64'(cnt_hist[b]), 2);
    chk(bm_hist[b+1] == 16'h0001, "R7 second bitmap",    64'(bm_hist[b+1]), 64'h0001);
    chk(cnt_hist[b+1] == CW'(1),  "R7 second count",     64'(cnt_hist[b+1]), 1);
    chk(ng == 3 && got[2] == 8'h05, "R7 pointer stream", 64'(got[2]), 64'h05);

    // R10: array longer than N_ENTRIES
    ng = 0; b = nbv;
    for (int i = 0; i < N + 4; i++) begin
      drive(1'b1, i == 0, i == N + 3, (i < N) ? PW'(i) : PW'(8'h80 + i));
    end
    idle();
    #1;
    chk(nbv == b + 1,           "R10 pulse on late last", 64'(nbv - b), 1);
    chk(bm_hist[b] == 16'hFFFF, "R10 bitmap",             64'(bm_hist[b]), 64'hFFFF);
    chk(ng == 16,               "R10 extra entries dropped", 64'(ng), 16);
    chk(cnt_hist[b] == CW'(16), "R10 count",              64'(cnt_hist[b]), 16);

    // R11: single-entry array
    ng = 0; b = nbv;
    drive(1'b1, 1'b1, 1'b1, 8'h3C);
    idle();
    #1;
    chk(nbv == b + 1 && bm_hist[b] == 16'h0001, "R11 bitmap", 64'(bm_hist[b]), 64'h0001);
    chk(cnt_hist[b] == CW'(1) && ng == 1 && got[0] == 8'h3C, "R11 pointer",
        64'(got[0]), 64'h3C);

    // R9: entries outside an array
    ng = 0; b = nbv;
    drive(1'b1, 1'b0, 1'b0, 8'hAA);
    drive(1'b1, 1'b0, 1'b0, 8'hBB);
    drive(1'b1, 1'b0, 1'b1, 8'hCC);
    idle(); idle();
    #1;
    chk(ng == 0,                 "R9 no pointer out",  64'(ng), 0);
    chk(nbv == b,                "R9 no pulse",        64'(nbv - b), 0);
    chk(bitmap == 16'h0001,      "R9 bitmap kept",     64'(bitmap), 64'h0001);
    chk(out_count == CW'(1),     "R9 count kept",      64'(out_count), 1);

    // R1: asynchronous reset mid-run
    drive(1'b1, 1'b1, 1'b0, 8'h12);
    drive(1'b1, 1'b0, 1'b0, 8'h34);
    #1;
    rst_n = 0;
    #1;
    chk(bitmap == '0 && out_count == '0 && !out_valid, "R1 async reset",
        64'(bitmap), 0);
    in_valid = 0; in_start = 0; in_last = 0; in_ptr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule